// File: doc/BRIEF.md
# Presettable Counter Stage with Carry

This block is a four-bit counter stage. All of its state bits change together on the rising clock edge. It can be preset from a parallel data input and cleared to zero, and it raises a carry flag when it reaches its top count so that a following stage can be enabled. Two build-time parameters shape each instance. One picks the modulus: decade, counting 0 to 9, or binary, counting 0 to 15. The other picks whether the clear acts at the next clock edge or at once, without a clock.

Counting is gated by two enables with different roles. Both enables must be high for the stage to advance. Only the trailing enable (`en_t`) reaches the carry flag, so a chain of stages can propagate an enable without waiting for a clock. Clear outranks load, and load outranks counting. A synchronous active-high `rst` returns the stage to zero under either clear option.

Top module: `presettable_counter_stage`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0 after that edge, and `carry_out` then reads 0.
- R2: When `clear_n`, `load_n`, `en_p` and `en_t` are all high at a rising edge, `count` increases by exactly one at that edge.
- R3: If either `en_p` or `en_t` is low, with `clear_n` and `load_n` high, `count` keeps its value across the edge.
- R4: `load_n` low at a rising edge copies `din` into `count`, whatever the levels of both enables.
- R5: A low `clear_n` wins over a simultaneous low `load_n`, and the result is 0.
- R6: With `DIRECT_CLEAR`=0, a low `clear_n` gives `count`=0 after the next rising edge, even when both enables are high.
- R7: With `DIRECT_CLEAR`=1, a low `clear_n` forces `count` to 0 at once, before any clock edge. The count stays 0 while `clear_n` is low, whatever `load_n` and the enables do.
- R8: A counting edge at the top value wraps `count` to 0. The top value is 9 with `IS_DECADE`=1 and 15 with `IS_DECADE`=0.
- R9: `carry_out` equals (`en_t` high AND `count` equal to the top value). It is combinational, so it follows `en_t` without a clock edge, and `en_p` has no influence on it.
- R10: With `IS_DECADE`=1, a loaded value from 10 to 15 keeps counting upward and wraps from 15 to 0, and `carry_out` stays low at those values.
- R11: Changing `en_p`, `en_t`, `load_n` or `din` between edges leaves `count` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high, sets the count to 0 |
| clear_n | input | 1 | Active-low clear; timing is chosen by `DIRECT_CLEAR` |
| load_n | input | 1 | Active-low synchronous preset from `din` |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| din | input | 4 | Preset value |
| count | output | 4 | Current count |
| carry_out | output | 1 | High while `en_t` is high and the count is at its top value |

## Verification
The bench builds two instances side by side. One is a decade counter with edge-timed clear, and it covers the 9-to-0 wrap, the out-of-range values 10 to 15 after a preset, and clear winning over load at an edge. The other is a binary counter with direct clear, and it covers the 15-to-0 wrap, the carry at 15, and a clear that takes effect between edges while a load is pending. Mid-cycle samples of both instances show that enable and load changes leave the count alone until the next edge, while the carry follows `en_t` at once.

// File: rtl/cstage_pkg.sv
package cstage_pkg;

    localparam int STAGE_W = 4;

    typedef logic [STAGE_W-1:0] cval_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cstage_op_e;

    typedef struct packed {
        logic  clear;
        logic  load;
        logic  advance;
        cval_t preset;
    } cstage_ctl_t;

    function automatic cval_t top_value(input bit decade);
        return decade ? cval_t'(9) : {STAGE_W{1'b1}};
    endfunction

    function automatic cval_t bump(input cval_t cur, input cval_t top);
        return (cur == top) ? '0 : cur + cval_t'(1);
    endfunction

endpackage

// File: rtl/cstage_ctrl.sv
module cstage_ctrl
    import cstage_pkg::*;
#(
    parameter bit DIRECT_CLEAR = 1'b0
) (
    input  logic        clear_n,
    input  logic        load_n,
    input  logic        en_p,
    input  logic        en_t,
    input  cval_t       din,
    output cstage_ctl_t ctl,
    output cstage_op_e  op
);
    always_comb begin
        ctl.clear   = !clear_n && !DIRECT_CLEAR;
        ctl.load    = !load_n;
        ctl.advance = en_p && en_t;
        ctl.preset  = din;
    end

    always_comb begin
        if (ctl.clear)        op = OP_CLEAR;
        else if (ctl.load)    op = OP_LOAD;
        else if (ctl.advance) op = OP_COUNT;
        else                  op = OP_HOLD;
    end
endmodule

// File: rtl/cstage_next.sv
module cstage_next
    import cstage_pkg::*;
#(
    parameter bit IS_DECADE = 1'b0
) (
    input  cstage_op_e  op,
    input  cstage_ctl_t ctl,
    input  cval_t       cur,
    output cval_t       nxt
);
    localparam cval_t TOP = top_value(IS_DECADE);

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = ctl.preset;
            OP_COUNT: nxt = bump(cur, TOP);
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/cstage_reg.sv
module cstage_reg
    import cstage_pkg::*;
#(
    parameter bit DIRECT_CLEAR = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clear_n,
    input  cval_t nxt,
    output cval_t cur
);
    generate
        if (DIRECT_CLEAR) begin : g_direct
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n)  cur <= '0;
                else if (rst)  cur <= '0;
                else           cur <= nxt;
            end

            p_direct_clear_r7: assert property (@(posedge clk) disable iff (rst)
                !clear_n |-> (cur == '0));
        end else begin : g_edge
            always_ff @(posedge clk) begin
                if (rst) cur <= '0;
                else     cur <= nxt;
            end

            p_edge_clear_r6: assert property (@(posedge clk) disable iff (rst)
                !clear_n |=> (cur == '0));
        end
    endgenerate
endmodule

// File: rtl/cstage_carry.sv
module cstage_carry
    import cstage_pkg::*;
#(
    parameter bit IS_DECADE = 1'b0
) (
    input  cval_t cur,
    input  logic  en_t,
    output logic  carry
);
    localparam cval_t TOP = top_value(IS_DECADE);

    always_comb carry = en_t && (cur == TOP);
endmodule

// File: rtl/presettable_counter_stage.sv
module presettable_counter_stage
    import cstage_pkg::*;
#(
    parameter bit IS_DECADE    = 1'b0,
    parameter bit DIRECT_CLEAR = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear_n,
    input  logic               load_n,
    input  logic               en_p,
    input  logic               en_t,
    input  logic [STAGE_W-1:0] din,
    output logic [STAGE_W-1:0] count,
    output logic               carry_out
);
    localparam cval_t TOP = top_value(IS_DECADE);

    cstage_ctl_t ctl;
    cstage_op_e  op;
    cval_t       nxt;
    cval_t       cur;

    cstage_ctrl #(.DIRECT_CLEAR(DIRECT_CLEAR)) u_ctrl (
        .clear_n (clear_n),
        .load_n  (load_n),
        .en_p    (en_p),
        .en_t    (en_t),
        .din     (din),
        .ctl     (ctl),
        .op      (op)
    );

    cstage_next #(.IS_DECADE(IS_DECADE)) u_next (
        .op  (op),
        .ctl (ctl),
        .cur (cur),
        .nxt (nxt)
    );

    cstage_reg #(.DIRECT_CLEAR(DIRECT_CLEAR)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .clear_n (clear_n),
        .nxt     (nxt),
        .cur     (cur)
    );

    cstage_carry #(.IS_DECADE(IS_DECADE)) u_carry (
        .cur   (cur),
        .en_t  (en_t),
        .carry (carry_out)
    );

    assign count = cur;

    // R2: a counting edge below the wrap point adds exactly one
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && en_p && en_t && count != TOP && count != {STAGE_W{1'b1}})
        |=> (!clear_n || count == $past(count) + cval_t'(1)));

    // R3: a missing enable freezes the count
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && !(en_p && en_t)) |=> (!clear_n || $stable(count)));

    // R4: a preset lands on the next edge
    p_preset_r4: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !load_n) |=> (!clear_n || count == $past(din)));

    // R8: counting at the top value returns to zero
    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && en_p && en_t && count == TOP) |=> (count == '0));

    // R9: the carry needs en_t and the top value
    p_carry_r9: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> (en_t && count == TOP));
endmodule

// File: tb/presettable_counter_stage_test.sv
module presettable_counter_stage_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr_a_n = 1'b1;
    logic       clr_b_n = 1'b1;
    logic       load_n = 1'b1;
    logic       en_p = 1'b0;
    logic       en_t = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] count_a, count_b;
    logic       carry_a, carry_b;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [3:0] mdl_a = 4'd0;
    logic [3:0] mdl_b = 4'd0;

    typedef struct {
        logic [3:0] exp_a;
        logic [3:0] exp_b;
        logic       exp_ca;
        logic       exp_cb;
        string      tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #10 clk = ~clk;

    // decade counter, clear taken at the edge
    presettable_counter_stage #(.IS_DECADE(1'b1), .DIRECT_CLEAR(1'b0)) uut (
        .clk(clk), .rst(rst), .clear_n(clr_a_n), .load_n(load_n),
        .en_p(en_p), .en_t(en_t), .din(din), .count(count_a), .carry_out(carry_a)
    );

    // binary counter, clear acting without a clock
    presettable_counter_stage #(.IS_DECADE(1'b0), .DIRECT_CLEAR(1'b1)) uut_b (
        .clk(clk), .rst(rst), .clear_n(clr_b_n), .load_n(load_n),
        .en_p(en_p), .en_t(en_t), .din(din), .count(count_b), .carry_out(carry_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model(input logic [3:0] q, input logic [3:0] top,
                                         input bit r, input bit ld_n, input bit cl_n,
                                         input bit ep, input bit et, input logic [3:0] d);
        if (r || !cl_n)  return 4'd0;
        if (!ld_n)       return d;
        if (ep && et)    return (q == top) ? 4'd0 : q + 4'd1;
        return q;
    endfunction

    // driver: apply one cycle of stimulus, check mid-cycle, push expectation
    task automatic step(input bit r, input bit ld_n, input bit ca_n, input bit cb_n,
                        input bit ep, input bit et, input logic [3:0] d, input string tag);
        sb_item_t it;
        @(negedge clk);
        rst = r; load_n = ld_n; clr_a_n = ca_n; clr_b_n = cb_n;
        en_p = ep; en_t = et; din = d;
        #3;
        chk(count_a == mdl_a, {"R11 mid-cycle count_a ", tag}, count_a, mdl_a);
        chk(carry_a == (et && mdl_a == 4'd9), {"R9 mid-cycle carry_a ", tag},
            carry_a, et && mdl_a == 4'd9);
        if (cb_n) begin
            chk(count_b == mdl_b, {"R11 mid-cycle count_b ", tag}, count_b, mdl_b);
            chk(carry_b == (et && mdl_b == 4'd15), {"R9 mid-cycle carry_b ", tag},
                carry_b, et && mdl_b == 4'd15);
        end else begin
            chk(count_b == 4'd0, {"R7 direct clear before edge ", tag}, count_b, 0);
        end
        mdl_a = model(mdl_a, 4'd9,  r, ld_n, ca_n, ep, et, d);
        mdl_b = model(mdl_b, 4'd15, r, ld_n, cb_n, ep, et, d);
        it.exp_a  = mdl_a;
        it.exp_b  = mdl_b;
        it.exp_ca = et && mdl_a == 4'd9;
        it.exp_cb = et && mdl_b == 4'd15;
        it.tag    = tag;
        sb.push_back(it);
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #5;
        if (sb.size() > 0) begin
            sb_item_t got;
            got = sb.pop_front();
            chk(count_a == got.exp_a, {"count_a ", got.tag}, count_a, got.exp_a);
            chk(count_b == got.exp_b, {"count_b ", got.tag}, count_b, got.exp_b);
            chk(carry_a == got.exp_ca, {"carry_a ", got.tag}, carry_a, got.exp_ca);
            chk(carry_b == got.exp_cb, {"carry_b ", got.tag}, carry_b, got.exp_cb);
        end
    end

    initial begin
        step(1, 1, 1, 1, 1, 1, 4'd0, "R1 reset");
        step(1, 0, 1, 1, 1, 1, 4'd6, "R1 reset over load");
        for (int i = 0; i < 9; i++) step(0, 1, 1, 1, 1, 1, 4'd0, "R2 count up");
        step(0, 1, 1, 1, 0, 1, 4'd0, "R3 R9 hold en_p low at top");
        step(0, 1, 1, 1, 1, 0, 4'd0, "R3 R9 hold en_t low");
        step(0, 1, 1, 1, 1, 1, 4'd0, "R8 decade wrap");
        for (int i = 0; i < 5; i++) step(0, 1, 1, 1, 1, 1, 4'd0, "R2 R8 binary approach");
        step(0, 1, 1, 1, 1, 1, 4'd0, "R8 binary wrap");
        step(0, 0, 1, 1, 0, 0, 4'd13, "R4 load enables low");
        step(0, 1, 1, 1, 1, 1, 4'd0, "R10 count 13 to 14");
        step(0, 1, 1, 1, 1, 1, 4'd0, "R10 count 14 to 15");
        step(0, 1, 1, 1, 1, 1, 4'd0, "R10 R8 wrap 15");
        step(0, 0, 1, 1, 1, 1, 4'd5, "R4 load over count");
        step(0, 0, 0, 1, 1, 1, 4'd11, "R5 clear beats load");
        step(0, 1, 1, 1, 1, 1, 4'd0, "R2 count after clear");
        step(0, 0, 1, 0, 1, 1, 4'd3, "R7 direct clear with load");
        step(0, 1, 1, 1, 1, 1, 4'd0, "R7 release direct clear");
        step(0, 1, 0, 1, 1, 1, 4'd0, "R6 edge clear enables high");
        step(0, 1, 1, 1, 0, 0, 4'd0, "R3 idle");
        repeat (2) @(posedge clk);
        #7;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 5000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule